// File: doc/BRIEF.md
# Sensor Row Zero-Bias Corrector

This block captures one 64 by 64 frame from an external image sensor, one row at a time, and removes the dark offset from each row before it is stored. Every row comes in as 66 signed bytes: 64 active pixels, then 2 pixels that are masked from light. The block averages the two masked pixels to get the row's offset, subtracts that offset from each active pixel of the same row, and writes the results into an internal frame buffer. It then reads the next row.

A host starts a capture by writing to the control address. It polls a status bit, or watches the `capture_done` pin, until the frame is complete. It then reads the corrected frame byte by byte at offsets in row-major order. A fixed sequence of phases runs for every row: wait, collect the row, compute the offset, correct the row, advance to the next row. Sensor timing, analog readout and any later compression stay outside the block.

Top module: `zb_row_corrector`

## Requirements
- R1: After reset, `capture_done` is 0 and `host_rd_valid` is 0.
- R2: A `host_wr` with `host_addr[12]` = 1 starts a capture when no capture is running, and `capture_done` reads 0 from the next cycle. A control write during a running capture is ignored and does not restart it.
- R3: In the row-collect phase, each cycle with `px_valid` = 1 takes one byte. Bytes 0 to 63 of a row are the active pixels (column order) and bytes 64 and 65 are the two masked reference pixels. A `px_valid` outside the row-collect phase is ignored.
- R4: The row offset is the 9-bit signed sum of the two reference pixels divided by two, truncated toward zero (for example, -7 gives -3 and -1 gives 0).
- R5: Each stored pixel equals the active pixel minus the row offset, wrapped to 8-bit two's complement.
- R6: For each row the phases run in the order collect, compute offset, correct, advance. The advance phase returns to collect until row 63 is done, then goes to idle.
- R7: `capture_done` rises once all 64 rows are corrected, and it stays 1 until the next accepted start.
- R8: A `host_rd` with `host_addr[12]` = 0 while no capture runs returns the byte of row `addr[11:6]` and column `addr[5:0]` on `host_rd_data`, with `host_rd_valid` = 1, on the following cycle.
- R9: A frame-buffer read issued while a capture runs is ignored: `host_rd_valid` stays 0 on the following cycle.
- R10: A `host_rd` with `host_addr[12]` = 1 returns the status byte on the following cycle at any time. Bit 0 of that byte is the done bit and the other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| px_valid | input | 1 | Sensor byte strobe |
| px_data | input | 8 | Sensor byte, signed |
| host_wr | input | 1 | Host write strobe (control address only) |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 13 | Host byte address; bit 12 selects control/status |
| host_rd_data | output | 8 | Read data, one cycle after `host_rd` |
| host_rd_valid | output | 1 | Read data valid |
| capture_done | output | 1 | Frame fully corrected |

## Verification
The assertions check the following on every cycle: the phase order within a row, the exit from the advance phase, the clearing of done at a start and its holding afterwards, the offset staying constant while a row is corrected, and whether each host read gets a reply. Only the bench scenarios can show the arithmetic. These are the truncation of negative odd sums, the wrap at the extremes (offsets of 127 and -128), the row-major placement of every byte, and the fact that stray sensor strobes and restart attempts in mid-frame leave the stored frame unchanged.

// File: rtl/zb_pkg.sv
package zb_pkg;
  parameter int ZB_PIX_W = 8;

  typedef enum logic [2:0] {
    ZB_IDLE,
    ZB_GET_ROW,
    ZB_CALC_BIAS,
    ZB_FIX_BIAS,
    ZB_NEXT_ROW
  } zb_state_e;

  // Half of the sum of two reference pixels, rounded toward zero.
  function automatic logic [ZB_PIX_W-1:0] zb_row_bias(
      input logic [ZB_PIX_W-1:0] a, input logic [ZB_PIX_W-1:0] b);
    logic [ZB_PIX_W:0] s;
    s = {a[ZB_PIX_W-1], a} + {b[ZB_PIX_W-1], b};
    if (s[ZB_PIX_W]) s = s + 1'b1;  // negative: bias up before halving
    return s[ZB_PIX_W:1];
  endfunction

  // Pixel minus offset, modulo 2**ZB_PIX_W.
  function automatic logic [ZB_PIX_W-1:0] zb_correct(
      input logic [ZB_PIX_W-1:0] px, input logic [ZB_PIX_W-1:0] bias);
    return px - bias;
  endfunction
endpackage

// File: rtl/zb_row_store.sv
module zb_row_store #(
  parameter int COLS = 64,
  parameter int W    = 8,
  parameter int IW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [COLS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/zb_frame_ram.sv
module zb_frame_ram #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH),
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/zb_ctrl.sv
module zb_ctrl
  import zb_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int TOTAL = 66,
  parameter int CW    = $clog2(TOTAL),
  parameter int RW    = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          px_valid_i,
  output zb_state_e     state_o,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic          done_o
);
  zb_state_e     state;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ZB_IDLE;
      col   <= '0;
      row   <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ZB_IDLE: if (start_i) begin
          state <= ZB_GET_ROW;
          row   <= '0;
          col   <= '0;
          done  <= 1'b0;
        end
        ZB_GET_ROW: if (px_valid_i) begin
          if (col == CW'(TOTAL - 1)) begin
            col   <= '0;
            state <= ZB_CALC_BIAS;
          end else begin
            col <= col + 1'b1;
          end
        end
        ZB_CALC_BIAS: begin
          col   <= '0;
          state <= ZB_FIX_BIAS;
        end
        ZB_FIX_BIAS: begin
          if (col == CW'(COLS - 1)) begin
            col   <= '0;
            state <= ZB_NEXT_ROW;
          end else begin
            col <= col + 1'b1;
          end
        end
        ZB_NEXT_ROW: begin
          if (row == RW'(ROWS - 1)) begin
            state <= ZB_IDLE;
            done  <= 1'b1;
          end else begin
            row   <= row + 1'b1;
            state <= ZB_GET_ROW;
          end
        end
        default: state <= ZB_IDLE;
      endcase
    end
  end

  assign state_o = state;
  assign col_o   = col;
  assign row_o   = row;
  assign done_o  = done;
endmodule

// File: rtl/zb_row_corrector.sv
module zb_row_corrector
  import zb_pkg::*;
#(
  parameter int ROWS = 64,  // power of two
  parameter int COLS = 64   // power of two
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           px_valid,
  input  logic [ZB_PIX_W-1:0]            px_data,
  input  logic                           host_wr,
  input  logic                           host_rd,
  input  logic [$clog2(ROWS*COLS):0]     host_addr,
  output logic [ZB_PIX_W-1:0]            host_rd_data,
  output logic                           host_rd_valid,
  output logic                           capture_done
);
  localparam int PIX_W   = ZB_PIX_W;
  localparam int REF_PIX = 2;
  localparam int TOTAL   = COLS + REF_PIX;
  localparam int CW      = $clog2(TOTAL);
  localparam int RW      = $clog2(ROWS);
  localparam int IW      = $clog2(COLS);
  localparam int FAW     = RW + IW;
  localparam int DEPTH   = ROWS * COLS;

  // Named events shared with the checker
  zb_state_e     st;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          start_evt;
  logic          capture_active;
  logic          px_take;
  logic          fix_wr;
  logic          buf_rd;
  logic          stat_rd;
  logic          addr_ctrl;

  logic [PIX_W-1:0] ref_a, ref_b, bias_q;
  logic [PIX_W-1:0] row_px, fixed_px, ram_q;
  logic             rd_valid_q, sel_stat_q;

  assign addr_ctrl      = host_addr[FAW];
  assign start_evt      = host_wr && addr_ctrl;
  assign capture_active = (st != ZB_IDLE);
  assign px_take        = (st == ZB_GET_ROW) && px_valid;
  assign fix_wr         = (st == ZB_FIX_BIAS);
  assign buf_rd         = host_rd && !addr_ctrl && !capture_active;
  assign stat_rd        = host_rd && addr_ctrl;

  zb_ctrl #(.ROWS(ROWS), .COLS(COLS), .TOTAL(TOTAL), .CW(CW), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .px_valid_i(px_valid),
    .state_o(st), .col_o(col), .row_o(row), .done_o(capture_done)
  );

  zb_row_store #(.COLS(COLS), .W(PIX_W), .IW(IW)) u_row (
    .clk(clk),
    .wr_en(px_take && (col < CW'(COLS))),
    .wr_idx(col[IW-1:0]),
    .wr_data(px_data),
    .rd_idx(col[IW-1:0]),
    .rd_data(row_px)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a  <= '0;
      ref_b  <= '0;
      bias_q <= '0;
    end else begin
      if (px_take && col == CW'(COLS))     ref_a <= px_data;
      if (px_take && col == CW'(COLS + 1)) ref_b <= px_data;
      if (st == ZB_CALC_BIAS)              bias_q <= zb_row_bias(ref_a, ref_b);
    end
  end

  assign fixed_px = zb_correct(row_px, bias_q);

  zb_frame_ram #(.DEPTH(DEPTH), .AW(FAW), .W(PIX_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .we(fix_wr), .waddr({row, col[IW-1:0]}), .wdata(fixed_px),
    .re(buf_rd), .raddr(host_addr[FAW-1:0]), .rdata(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      sel_stat_q <= 1'b0;
    end else begin
      rd_valid_q <= buf_rd || stat_rd;
      sel_stat_q <= stat_rd;
    end
  end

  assign host_rd_valid = rd_valid_q;
  assign host_rd_data  = sel_stat_q ? {{(PIX_W-1){1'b0}}, capture_done} : ram_q;
endmodule

// File: rtl/zb_checker.sv
module zb_checker
  import zb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input zb_state_e           st,
  input logic                start_evt,
  input logic                host_rd,
  input logic                addr_ctrl,
  input logic                capture_active,
  input logic                host_rd_valid,
  input logic                capture_done,
  input logic [ZB_PIX_W-1:0] bias_q
);
  assert_calc_to_fix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ZB_CALC_BIAS |=> st == ZB_FIX_BIAS);

  assert_next_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ZB_NEXT_ROW |=> (st == ZB_GET_ROW || st == ZB_IDLE));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ZB_IDLE && start_evt) |=> (st == ZB_GET_ROW && !capture_done));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_done && !start_evt) |=> capture_done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_done |-> st == ZB_IDLE);

  assert_bias_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ZB_FIX_BIAS && $past(st) == ZB_FIX_BIAS) |-> $stable(bias_q));

  assert_busy_read_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !addr_ctrl && capture_active) |=> !host_rd_valid);

  assert_read_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (addr_ctrl || !capture_active)) |=> host_rd_valid);
endmodule

bind zb_row_corrector zb_checker u_zb_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .start_evt(start_evt),
  .host_rd(host_rd), .addr_ctrl(addr_ctrl), .capture_active(capture_active),
  .host_rd_valid(host_rd_valid), .capture_done(capture_done), .bias_q(bias_q)
);

// File: tb/zb_row_corrector_bench.sv
module zb_row_corrector_bench;
  localparam int NR = 64;
  localparam int NC = 64;
  localparam int CTRL_ADDR = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        px_valid = 1'b0;
  logic [7:0]  px_data = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [12:0] host_addr = '0;
  logic [7:0]  host_rd_data;
  logic        host_rd_valid;
  logic        capture_done;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_frame [NR*NC];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  zb_row_corrector u_zb_row_corrector (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_data(px_data),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
    .capture_done(capture_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Monitor: pops expected read replies in order
  always @(negedge clk) begin
    if (rst_n && host_rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected reply", int'(host_rd_data), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rd_data === e, t, int'(host_rd_data), int'(e));
      end
    end
  end

  function automatic logic [7:0] pix(input int sel, input int r, input int c);
    return 8'(r * 37 + c * 11 + sel * 91);
  endfunction

  task automatic refs(input int k, output logic [7:0] a, output logic [7:0] b);
    case (k % 8)
      0: begin a = 8'd3;    b = 8'd4;    end
      1: begin a = -8'sd3;  b = -8'sd4;  end  // -7 -> -3
      2: begin a = 8'd127;  b = 8'd127;  end
      3: begin a = 8'h80;   b = 8'h80;   end  // -128
      4: begin a = -8'sd1;  b = 8'd0;    end  // -1 -> 0
      5: begin a = 8'd5;    b = -8'sd6;  end
      6: begin a = 8'd0;    b = 8'd0;    end
      default: begin a = 8'd100; b = -8'sd27; end
    endcase
  endtask

  task automatic host_cmd();
    @(negedge clk); host_wr = 1'b1; host_addr = 13'(CTRL_ADDR);
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic read_status(input logic [7:0] e);
    @(negedge clk); host_rd = 1'b1; host_addr = 13'(CTRL_ADDR);
    exp_q.push_back(e); tag_q.push_back("R10 status");
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_ignored();
    @(negedge clk); host_rd = 1'b1; host_addr = 13'd77;
    @(negedge clk); host_rd = 1'b0;
    chk(host_rd_valid == 1'b0, "R9 busy read", int'(host_rd_valid), 0);
  endtask

  task automatic read_frame();
    for (int a = 0; a < NR*NC; a++) begin
      @(negedge clk); host_rd = 1'b1; host_addr = 13'(a);
      exp_q.push_back(exp_frame[a]); tag_q.push_back("R5/R8 frame byte");
    end
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk);
  endtask

  // One row, then a gap with stray strobes (R3)
  task automatic drive_row(input int sel, input int r, input bit last);
    logic [7:0] ra, rb;
    int bias;
    refs(r + sel * 3, ra, rb);
    bias = (int'($signed(ra)) + int'($signed(rb))) / 2;  // R4
    for (int c = 0; c < NC + 2; c++) begin
      @(negedge clk);
      px_valid = 1'b1;
      if (c < NC) begin
        px_data = pix(sel, r, c);
        exp_frame[r*NC + c] = 8'(int'($signed(px_data)) - bias);  // R5
      end else begin
        px_data = (c == NC) ? ra : rb;
      end
    end
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (last && i == 0)
        chk(capture_done == 1'b0, "R7 done early", int'(capture_done), 0);
      px_valid = (i < 60);
      px_data  = 8'(8'hA5 ^ i);
    end
  endtask

  task automatic capture(input int sel, input bit disturb);
    for (int r = 0; r < NR; r++) begin
      drive_row(sel, r, r == NR - 1);
      if (disturb && r == 5) begin
        read_ignored();                 // R9
        read_status(8'd0);              // R10 during capture
        host_cmd();                     // R2 restart ignored
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(capture_done == 1'b0, "R1 done", int'(capture_done), 0);
    chk(host_rd_valid == 1'b0, "R1 rd_valid", int'(host_rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_status(8'd0);                  // R10 idle
    host_cmd();                         // R2 start
    capture(0, 1'b1);                   // R3 R4 R5 R6
    chk(capture_done == 1'b1, "R7 done set", int'(capture_done), 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(capture_done == 1'b1, "R7 done held", int'(capture_done), 1);
    end
    read_status(8'd1);                  // R10 done bit
    read_frame();                       // R5 R8
    host_cmd();
    chk(capture_done == 1'b0, "R2 done cleared", int'(capture_done), 0);
    capture(1, 1'b0);
    chk(capture_done == 1'b1, "R6 all rows", int'(capture_done), 1);
    read_frame();
    chk(exp_q.size() == 0, "R8 replies drained", exp_q.size(), 0);
    summary();
  end
endmodule